// File: doc/BRIEF.md
# VGA Register File Model

This block is a byte-wide model of the standard VGA I/O register set. Firmware that expects VGA hardware can program display registers on a platform that has no real VGA decode. Each clock cycle it takes at most one port access. A write carries a 16-bit port number and up to two data bytes. A read returns one byte on a registered output.

The block holds the following registers: the attribute, sequencer, graphics and CRTC index/data pairs, the palette DAC with its read and write pointers and its pixel mask, the miscellaneous output register and the input status register. It reproduces the behaviour that firmware relies on:

- a hidden flip-flop that makes one port serve as both attribute index and attribute data;
- a status register that changes its own bits each time it is read;
- palette pointers that count single colour components;
- CRTC access that depends on a bit of the miscellaneous register.

A 16-bit write into the VGA window is applied as two byte writes in the same cycle. The low byte goes to the addressed port first. The high byte then goes to the next port up, and it sees any index the low byte just changed.

Top module: `vga_regfile_model`

## Requirements
- R1: After reset, every index, pointer, array entry, the miscellaneous, mask and status registers, the attribute flip-flop and `rdata` are all 0.
- R2: Port 0x3C0 accesses the attribute index when the flip-flop is 0 and the attribute entry at that index when it is 1. Every read or write of 0x3C0 inverts the flip-flop. A read of 0x3C1 returns the entry at the current index and leaves the flip-flop alone.
- R3: A read of 0x3DA returns the stored status byte, clears the attribute flip-flop, and then XORs the stored status with 0x09.
- R4: The miscellaneous register is written at 0x3C2 and read at 0x3CC. A read of 0x3C2 returns 0xFF.
- R5: While bit 0 of the miscellaneous register is 0, writes to 0x3D4 (CRTC index) and 0x3D5 (CRTC data) change nothing, and reads of both return 0xFF. While the bit is 1, both ports work as a normal index/data pair.
- R6: A write to 0x3C8 (palette write pointer) or 0x3C7 (palette read pointer) stores three times the byte written. Each write or read at 0x3C9 uses the matching pointer as a byte address and then increments it. Reads of 0x3C7 and 0x3C8 return the low 8 bits of the pointer.
- R7: An indexed data access whose index or pointer is at or beyond the array size has no effect and does not move the pointer. A read of it returns 0xFF. A read of any port outside the mapped set also returns 0xFF. The array sizes are 21 attribute, 5 sequencer, 9 graphics and 25 CRTC registers, and 768 palette bytes.
- R8: A write with `wr_wide` set, to a port from 0x3C0 to 0x3DA, applies `wdata[7:0]` to that port and then `wdata[15:8]` to the port plus one, in the same cycle. The second byte sees the state that the first byte left.
- R9: `rdata` changes only in the cycle after a read. When `rd_en` and `wr_en` are both high, only the write happens and `rdata` holds its value.
- R10: 0x3C4/0x3C5 form the sequencer index/data pair and 0x3CE/0x3CF form the graphics index/data pair. The index ports read back the index. 0x3C6 holds the pixel mask for reading and writing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd_en | input | 1 | Read strobe for this cycle |
| wr_en | input | 1 | Write strobe for this cycle; wins over `rd_en` |
| wr_wide | input | 1 | With `wr_en`, the write is 16 bits wide |
| port | input | 16 | I/O port number |
| wdata | input | 16 | Write data; the upper byte is used only for wide writes |
| rdata | output | 8 | Registered read data |

## Verification
The bench targets the attribute flip-flop:
- a status read in the middle of an index/data pair must send the next 0x3C0 access back to the index;
- a 0x3C1 read must not advance the flip-flop, or every later attribute access is off by one.

The palette pointers are driven to index 255, so the pointer reaches 765 and then the array end. A model without the end stop would corrupt memory or wrap the pointer, and reads past the end would return stale data instead of 0xFF. The CRTC ports are accessed with the miscellaneous bit clear and then set, to catch gating that leaks writes. Wide writes to index/data pairs check that the high byte lands at the index that the low byte just wrote, and not at the old one.

// File: rtl/vga_rf_pkg.sv
package vga_rf_pkg;

  // Pointer width: holds 3 * 255 and the one-past-end value of the palette.
  localparam int PTR_W = 10;

  localparam logic [15:0] P_ATTR     = 16'h03C0;
  localparam logic [15:0] P_ATTR_RD  = 16'h03C1;
  localparam logic [15:0] P_MISC_WR  = 16'h03C2;
  localparam logic [15:0] P_SEQ_IX   = 16'h03C4;
  localparam logic [15:0] P_SEQ_DT   = 16'h03C5;
  localparam logic [15:0] P_DAC_MASK = 16'h03C6;
  localparam logic [15:0] P_PAL_RIX  = 16'h03C7;
  localparam logic [15:0] P_PAL_WIX  = 16'h03C8;
  localparam logic [15:0] P_PAL_DT   = 16'h03C9;
  localparam logic [15:0] P_MISC_RD  = 16'h03CC;
  localparam logic [15:0] P_GRA_IX   = 16'h03CE;
  localparam logic [15:0] P_GRA_DT   = 16'h03CF;
  localparam logic [15:0] P_CRT_IX   = 16'h03D4;
  localparam logic [15:0] P_CRT_DT   = 16'h03D5;
  localparam logic [15:0] P_STATUS   = 16'h03DA;
  localparam logic [15:0] P_WIN_LO   = 16'h03C0;
  localparam logic [15:0] P_WIN_HI   = 16'h03DA;

  localparam logic [7:0] STATUS_FLIP = 8'h09;
  localparam logic [7:0] RD_DEFAULT  = 8'hFF;

  typedef struct packed {
    logic             flip;
    logic [7:0]       att_ix;
    logic [7:0]       seq_ix;
    logic [7:0]       gra_ix;
    logic [7:0]       crt_ix;
    logic [7:0]       misc;
    logic [7:0]       mask;
    logic [7:0]       status;
    logic [PTR_W-1:0] pal_rp;
    logic [PTR_W-1:0] pal_wp;
  } ctl_t;

  typedef struct packed {
    logic             we;
    logic [PTR_W-1:0] addr;
    logic [7:0]       data;
  } wport_t;

endpackage

// File: rtl/vga_rf_bank.sv
module vga_rf_bank
  import vga_rf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wport_t           w_lo,
  input  wport_t           w_hi,
  input  logic [PTR_W-1:0] raddr,
  output logic [7:0]       rdata
);

  logic [7:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic       hit_lo, hit_hi, ent_en;
    logic [7:0] ent_d;

    always_comb begin
      hit_lo = w_lo.we && (int'(w_lo.addr) == e);
      hit_hi = w_hi.we && (int'(w_hi.addr) == e);
      ent_en = hit_lo | hit_hi;
      ent_d  = hit_hi ? w_hi.data : w_lo.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem[e] <= '0;
      else if (ent_en) mem[e] <= ent_d;
    end
  end

  assign rdata = (int'(raddr) < DEPTH) ? mem[raddr[AW-1:0]] : RD_DEFAULT;

endmodule

// File: rtl/vga_rf_wr_lane.sv
module vga_rf_wr_lane
  import vga_rf_pkg::*;
#(
  parameter int ATT_N = 21,
  parameter int SEQ_N = 5,
  parameter int GRA_N = 9,
  parameter int CRT_N = 25,
  parameter int PAL_N = 768
) (
  input  logic        en,
  input  logic [15:0] port,
  input  logic [7:0]  data,
  input  ctl_t        cur,
  output ctl_t        nxt,
  output wport_t      att_w,
  output wport_t      seq_w,
  output wport_t      gra_w,
  output wport_t      crt_w,
  output wport_t      pal_w
);

  logic [PTR_W-1:0] data_x3;
  assign data_x3 = ({2'b00, data} << 1) + {2'b00, data};

  always_comb begin
    nxt   = cur;
    att_w = '0;
    seq_w = '0;
    gra_w = '0;
    crt_w = '0;
    pal_w = '0;
    if (en) begin
      case (port)
        P_ATTR: begin
          if (!cur.flip) begin
            nxt.att_ix = data;
          end else if (int'(cur.att_ix) < ATT_N) begin
            att_w = '{we: 1'b1, addr: {2'b00, cur.att_ix}, data: data};
          end
          nxt.flip = ~cur.flip;
        end
        P_MISC_WR:  nxt.misc   = data;
        P_SEQ_IX:   nxt.seq_ix = data;
        P_SEQ_DT: begin
          if (int'(cur.seq_ix) < SEQ_N)
            seq_w = '{we: 1'b1, addr: {2'b00, cur.seq_ix}, data: data};
        end
        P_DAC_MASK: nxt.mask   = data;
        P_PAL_RIX:  nxt.pal_rp = data_x3;
        P_PAL_WIX:  nxt.pal_wp = data_x3;
        P_PAL_DT: begin
          if (int'(cur.pal_wp) < PAL_N) begin
            pal_w      = '{we: 1'b1, addr: cur.pal_wp, data: data};
            nxt.pal_wp = cur.pal_wp + PTR_W'(1);
          end
        end
        P_GRA_IX:   nxt.gra_ix = data;
        P_GRA_DT: begin
          if (int'(cur.gra_ix) < GRA_N)
            gra_w = '{we: 1'b1, addr: {2'b00, cur.gra_ix}, data: data};
        end
        P_CRT_IX: begin
          if (cur.misc[0]) nxt.crt_ix = data;
        end
        P_CRT_DT: begin
          if (cur.misc[0] && (int'(cur.crt_ix) < CRT_N))
            crt_w = '{we: 1'b1, addr: {2'b00, cur.crt_ix}, data: data};
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vga_regfile_model.sv
module vga_regfile_model
  import vga_rf_pkg::*;
#(
  parameter int ATT_N = 21,
  parameter int SEQ_N = 5,
  parameter int GRA_N = 9,
  parameter int CRT_N = 25,
  parameter int PAL_N = 768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic        wr_wide,
  input  logic [15:0] port,
  input  logic [15:0] wdata,
  output logic [7:0]  rdata
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  ctl_t   ctl_q, ctl_mid, ctl_wr, ctl_rd, ctl_d;
  logic   ctl_en, rd_act, in_win, hi_en;
  logic [15:0] hi_port;
  logic [7:0]  rd_val, rdata_q;
  wport_t att_lo, seq_lo, gra_lo, crt_lo, pal_lo;
  wport_t att_hi, seq_hi, gra_hi, crt_hi, pal_hi;
  logic [7:0] att_rd, seq_rd, gra_rd, crt_rd, pal_rd;

  assign in_win  = (port >= P_WIN_LO) && (port <= P_WIN_HI);
  assign hi_en   = wr_en && wr_wide && in_win;
  assign hi_port = port + 16'd1;
  assign rd_act  = rd_en && !wr_en;

  vga_rf_wr_lane #(.ATT_N(ATT_N), .SEQ_N(SEQ_N), .GRA_N(GRA_N), .CRT_N(CRT_N), .PAL_N(PAL_N))
  u_lane_lo (
    .en(wr_en), .port(port), .data(wdata[7:0]), .cur(ctl_q), .nxt(ctl_mid),
    .att_w(att_lo), .seq_w(seq_lo), .gra_w(gra_lo), .crt_w(crt_lo), .pal_w(pal_lo)
  );

  vga_rf_wr_lane #(.ATT_N(ATT_N), .SEQ_N(SEQ_N), .GRA_N(GRA_N), .CRT_N(CRT_N), .PAL_N(PAL_N))
  u_lane_hi (
    .en(hi_en), .port(hi_port), .data(wdata[15:8]), .cur(ctl_mid), .nxt(ctl_wr),
    .att_w(att_hi), .seq_w(seq_hi), .gra_w(gra_hi), .crt_w(crt_hi), .pal_w(pal_hi)
  );

  vga_rf_bank #(.DEPTH(ATT_N)) u_att (.clk(clk), .rst_n(rst_i), .w_lo(att_lo), .w_hi(att_hi),
    .raddr({2'b00, ctl_q.att_ix}), .rdata(att_rd));
  vga_rf_bank #(.DEPTH(SEQ_N)) u_seq (.clk(clk), .rst_n(rst_i), .w_lo(seq_lo), .w_hi(seq_hi),
    .raddr({2'b00, ctl_q.seq_ix}), .rdata(seq_rd));
  vga_rf_bank #(.DEPTH(GRA_N)) u_gra (.clk(clk), .rst_n(rst_i), .w_lo(gra_lo), .w_hi(gra_hi),
    .raddr({2'b00, ctl_q.gra_ix}), .rdata(gra_rd));
  vga_rf_bank #(.DEPTH(CRT_N)) u_crt (.clk(clk), .rst_n(rst_i), .w_lo(crt_lo), .w_hi(crt_hi),
    .raddr({2'b00, ctl_q.crt_ix}), .rdata(crt_rd));
  vga_rf_bank #(.DEPTH(PAL_N)) u_pal (.clk(clk), .rst_n(rst_i), .w_lo(pal_lo), .w_hi(pal_hi),
    .raddr(ctl_q.pal_rp), .rdata(pal_rd));

  // Read path: value returned and side effects of reading.
  always_comb begin
    ctl_rd = ctl_q;
    rd_val = RD_DEFAULT;
    case (port)
      P_ATTR: begin
        rd_val      = ctl_q.flip ? att_rd : ctl_q.att_ix;
        ctl_rd.flip = ~ctl_q.flip;
      end
      P_ATTR_RD:  rd_val = att_rd;
      P_MISC_RD:  rd_val = ctl_q.misc;
      P_SEQ_IX:   rd_val = ctl_q.seq_ix;
      P_SEQ_DT:   rd_val = seq_rd;
      P_DAC_MASK: rd_val = ctl_q.mask;
      P_PAL_RIX:  rd_val = ctl_q.pal_rp[7:0];
      P_PAL_WIX:  rd_val = ctl_q.pal_wp[7:0];
      P_PAL_DT: begin
        if (int'(ctl_q.pal_rp) < PAL_N) begin
          rd_val        = pal_rd;
          ctl_rd.pal_rp = ctl_q.pal_rp + PTR_W'(1);
        end
      end
      P_GRA_IX:   rd_val = ctl_q.gra_ix;
      P_GRA_DT:   rd_val = gra_rd;
      P_CRT_IX: begin
        if (ctl_q.misc[0]) rd_val = ctl_q.crt_ix;
      end
      P_CRT_DT: begin
        if (ctl_q.misc[0]) rd_val = crt_rd;
      end
      P_STATUS: begin
        rd_val        = ctl_q.status;
        ctl_rd.flip   = 1'b0;
        ctl_rd.status = ctl_q.status ^ STATUS_FLIP;
      end
      default: ;
    endcase
  end

  always_comb begin
    ctl_en = wr_en | rd_act;
    ctl_d  = wr_en ? ctl_wr : ctl_rd;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      rdata_q <= '0;
    else if (rd_act) rdata_q <= rd_val;
  end

  assign rdata = rdata_q;

  AST_ATTR_FLIP_TOGGLES: assert property (@(posedge clk) disable iff (!rst_i)
    ((rd_en || wr_en) && port == P_ATTR) |=> (ctl_q.flip != $past(ctl_q.flip))); // R2

  AST_STATUS_READ_EFFECT: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_act && port == P_STATUS) |=>
      ((ctl_q.status == ($past(ctl_q.status) ^ STATUS_FLIP)) && !ctl_q.flip)); // R3

  AST_CRT_GATED: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_en && !ctl_q.misc[0] && (port == P_CRT_IX || port == P_CRT_DT)) |=> $stable(ctl_q.crt_ix)); // R5

  AST_PAL_PTR_SCALED: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_en && !wr_wide && port == P_PAL_WIX) |=>
      (ctl_q.pal_wp == ($past({2'b00, wdata[7:0]}) * 10'd3))); // R6

  AST_PAL_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_i)
    (int'(ctl_q.pal_wp) <= PAL_N) && (int'(ctl_q.pal_rp) <= PAL_N)); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    !rd_act |=> $stable(rdata_q)); // R9

endmodule

// File: tb/vga_regfile_model_tb_top.sv
module vga_regfile_model_tb_top;

  localparam int ATT_N = 21;
  localparam int SEQ_N = 5;
  localparam int GRA_N = 9;
  localparam int CRT_N = 25;
  localparam int PAL_N = 768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0, wr_wide = 1'b0;
  logic [15:0] port = '0, wdata = '0;
  logic [7:0]  rdata;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  vga_regfile_model dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wr_wide(wr_wide),
    .port(port), .wdata(wdata), .rdata(rdata)
  );

  // Behavioural reference state
  int m_ff, m_ai, m_si, m_gi, m_ci, m_misc, m_mask, m_st, m_pr, m_pw;
  logic [7:0] m_att [ATT_N];
  logic [7:0] m_seq [SEQ_N];
  logic [7:0] m_gra [GRA_N];
  logic [7:0] m_crt [CRT_N];
  logic [7:0] m_pal [PAL_N];
  logic [7:0] m_exp = 8'h00;

  function automatic void m_reset();
    m_ff = 0; m_ai = 0; m_si = 0; m_gi = 0; m_ci = 0;
    m_misc = 0; m_mask = 0; m_st = 0; m_pr = 0; m_pw = 0;
    for (int i = 0; i < ATT_N; i++) m_att[i] = 8'h00;
    for (int i = 0; i < SEQ_N; i++) m_seq[i] = 8'h00;
    for (int i = 0; i < GRA_N; i++) m_gra[i] = 8'h00;
    for (int i = 0; i < CRT_N; i++) m_crt[i] = 8'h00;
    for (int i = 0; i < PAL_N; i++) m_pal[i] = 8'h00;
  endfunction

  function automatic void m_wr(int p, logic [7:0] d);
    int v;
    v = int'(d);
    case (p)
      'h3C0: begin
        if (m_ff == 0) m_ai = v;
        else if (m_ai < ATT_N) m_att[m_ai] = d;
        m_ff = 1 - m_ff;
      end
      'h3C2: m_misc = v;
      'h3C4: m_si = v;
      'h3C5: if (m_si < SEQ_N) m_seq[m_si] = d;
      'h3C6: m_mask = v;
      'h3C7: m_pr = v * 3;
      'h3C8: m_pw = v * 3;
      'h3C9: if (m_pw < PAL_N) begin m_pal[m_pw] = d; m_pw++; end
      'h3CE: m_gi = v;
      'h3CF: if (m_gi < GRA_N) m_gra[m_gi] = d;
      'h3D4: if (m_misc % 2 == 1) m_ci = v;
      'h3D5: if (m_misc % 2 == 1 && m_ci < CRT_N) m_crt[m_ci] = d;
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] m_rd(int p);
    logic [7:0] v;
    v = 8'hFF;
    case (p)
      'h3C0: begin
        if (m_ff == 0) v = 8'(m_ai);
        else if (m_ai < ATT_N) v = m_att[m_ai];
        m_ff = 1 - m_ff;
      end
      'h3C1: if (m_ai < ATT_N) v = m_att[m_ai];
      'h3CC: v = 8'(m_misc);
      'h3C4: v = 8'(m_si);
      'h3C5: if (m_si < SEQ_N) v = m_seq[m_si];
      'h3C6: v = 8'(m_mask);
      'h3C7: v = 8'(m_pr);
      'h3C8: v = 8'(m_pw);
      'h3C9: if (m_pr < PAL_N) begin v = m_pal[m_pr]; m_pr++; end
      'h3CE: v = 8'(m_gi);
      'h3CF: if (m_gi < GRA_N) v = m_gra[m_gi];
      'h3D4: if (m_misc % 2 == 1) v = 8'(m_ci);
      'h3D5: if (m_misc % 2 == 1 && m_ci < CRT_N) v = m_crt[m_ci];
      'h3DA: begin v = 8'(m_st); m_ff = 0; m_st = m_st ^ 'h09; end
      default: ;
    endcase
    return v;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: rdata=%02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // One access cycle; called at a negative edge, returns at the next one.
  task automatic acc(input logic r, input logic w, input logic wd, input logic [15:0] p,
                     input logic [15:0] d, input string tag);
    rd_en = r; wr_en = w; wr_wide = wd; port = p; wdata = d;
    @(posedge clk);
    if (w) begin
      m_wr(int'(p), d[7:0]);
      if (wd && p >= 16'h03C0 && p <= 16'h03DA) m_wr(int'(p) + 1, d[15:8]);
    end else if (r) begin
      m_exp = m_rd(int'(p));
    end
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; wr_wide = 1'b0;
    check(rdata, m_exp, {tag, " model"});
  endtask

  task automatic wr(input logic [15:0] p, input logic [7:0] d, input string tag);
    acc(1'b0, 1'b1, 1'b0, p, {8'h00, d}, tag);
  endtask

  task automatic wrw(input logic [15:0] p, input logic [15:0] d, input string tag);
    acc(1'b0, 1'b1, 1'b1, p, d, tag);
  endtask

  task automatic rdv(input logic [15:0] p, input logic [7:0] v, input string tag);
    acc(1'b1, 1'b0, 1'b0, p, 16'h0000, tag);
    check(rdata, v, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check(rdata, 8'h00, "R1 reset rdata");
    // R1 + R3: status starts at 0 and alternates bits 0 and 3
    rdv(16'h03DA, 8'h00, "R1 status reset");
    rdv(16'h03DA, 8'h09, "R3 status toggle");
    rdv(16'h03DA, 8'h00, "R3 status toggle back");

    // R2: attribute flip-flop
    wr(16'h03C0, 8'h05, "R2 attr index");
    wr(16'h03C0, 8'hA5, "R2 attr data");
    rdv(16'h03C0, 8'h05, "R2 read index");
    rdv(16'h03C0, 8'hA5, "R2 read data");
    rdv(16'h03C1, 8'hA5, "R2 read 3C1");
    rdv(16'h03C0, 8'h05, "R2 3C1 no toggle");
    rdv(16'h03DA, 8'h09, "R3 status mid pair");
    rdv(16'h03C0, 8'h05, "R3 flip cleared");
    rdv(16'h03DA, 8'h00, "R3 status");

    // R7: out-of-range attribute and unmapped ports
    wr(16'h03C0, 8'h20, "R7 attr idx oor");
    wr(16'h03C0, 8'h77, "R7 attr data dropped");
    rdv(16'h03C0, 8'h20, "R7 oor index readback");
    rdv(16'h03C0, 8'hFF, "R7 oor data read");
    rdv(16'h03C1, 8'hFF, "R7 oor 3C1 read");
    rdv(16'h03C3, 8'hFF, "R7 unmapped 3C3");
    rdv(16'h0080, 8'hFF, "R7 unmapped low port");

    // R4: miscellaneous register
    wr(16'h03C2, 8'h66, "R4 misc write");
    rdv(16'h03CC, 8'h66, "R4 misc readback");
    rdv(16'h03C2, 8'hFF, "R4 write port reads FF");

    // R5: CRTC gating
    wr(16'h03D4, 8'h03, "R5 gated index write");
    rdv(16'h03D4, 8'hFF, "R5 gated index read");
    wr(16'h03C2, 8'h67, "R5 enable");
    rdv(16'h03D4, 8'h00, "R5 index unchanged");
    wr(16'h03D4, 8'h03, "R5 index write");
    wr(16'h03D5, 8'hC3, "R5 data write");
    rdv(16'h03D5, 8'hC3, "R5 data readback");
    wr(16'h03C2, 8'h66, "R5 disable");
    rdv(16'h03D5, 8'hFF, "R5 gated data read");
    wr(16'h03D5, 8'h11, "R5 gated data write");
    wr(16'h03C2, 8'h67, "R5 re-enable");
    rdv(16'h03D5, 8'hC3, "R5 gated write dropped");
    wr(16'h03D4, 8'h19, "R7 crt idx oor");
    wr(16'h03D5, 8'h44, "R7 crt oor write");
    rdv(16'h03D5, 8'hFF, "R7 crt oor read");
    rdv(16'h03D4, 8'h19, "R5 index read");

    // R6: palette pointers
    wr(16'h03C8, 8'h02, "R6 write ptr");
    wr(16'h03C9, 8'h10, "R6 red");
    wr(16'h03C9, 8'h20, "R6 green");
    wr(16'h03C9, 8'h30, "R6 blue");
    rdv(16'h03C8, 8'h09, "R6 write ptr stepped");
    wr(16'h03C7, 8'h02, "R6 read ptr");
    rdv(16'h03C9, 8'h10, "R6 read red");
    rdv(16'h03C9, 8'h20, "R6 read green");
    rdv(16'h03C9, 8'h30, "R6 read blue");
    rdv(16'h03C7, 8'h09, "R6 read ptr stepped");
    wr(16'h03C8, 8'hFF, "R6 last entry");
    rdv(16'h03C8, 8'hFD, "R6 ptr 765 low byte");
    wr(16'h03C9, 8'hA1, "R6 last red");
    wr(16'h03C9, 8'hA2, "R6 last green");
    wr(16'h03C9, 8'hA3, "R6 last blue");
    wr(16'h03C9, 8'hA4, "R7 past end write");
    rdv(16'h03C8, 8'h00, "R7 ptr stops at 768");
    wr(16'h03C7, 8'hFF, "R6 read last");
    rdv(16'h03C9, 8'hA1, "R6 last red read");
    rdv(16'h03C9, 8'hA2, "R6 last green read");
    rdv(16'h03C9, 8'hA3, "R6 last blue read");
    rdv(16'h03C9, 8'hFF, "R7 past end read");
    rdv(16'h03C7, 8'h00, "R7 read ptr stops");

    // R10: sequencer, graphics, mask
    wr(16'h03C4, 8'h04, "R10 seq idx");
    wr(16'h03C5, 8'h5C, "R10 seq data");
    rdv(16'h03C4, 8'h04, "R10 seq idx read");
    rdv(16'h03C5, 8'h5C, "R10 seq data read");
    wr(16'h03C4, 8'h05, "R7 seq idx oor");
    wr(16'h03C5, 8'h99, "R7 seq oor write");
    rdv(16'h03C5, 8'hFF, "R7 seq oor read");
    wr(16'h03CE, 8'h08, "R10 gra idx");
    wr(16'h03CF, 8'hE7, "R10 gra data");
    rdv(16'h03CF, 8'hE7, "R10 gra read");
    wr(16'h03C6, 8'hF0, "R10 mask write");
    rdv(16'h03C6, 8'hF0, "R10 mask read");

    // R8: wide writes
    wrw(16'h03C4, 16'hBB01, "R8 wide seq");
    rdv(16'h03C4, 8'h01, "R8 seq idx from low byte");
    rdv(16'h03C5, 8'hBB, "R8 seq data from high byte");
    wrw(16'h03CE, 16'h4D02, "R8 wide gra");
    rdv(16'h03CF, 8'h4D, "R8 gra data");
    wrw(16'h03C8, 16'h3303, "R8 wide palette");
    rdv(16'h03C8, 8'h0A, "R8 palette ptr");
    wrw(16'h03D4, 16'h7E05, "R8 wide crt");
    rdv(16'h03D5, 8'h7E, "R8 crt data");
    acc(1'b1, 1'b0, 1'b0, 16'h03DA, 16'h0000, "R3 clear flip");
    wrw(16'h03C0, 16'h5507, "R8 wide attr");
    rdv(16'h03C0, 8'h00, "R8 attr data at idx 7");
    rdv(16'h03C1, 8'h00, "R8 high byte to 3C1 ignored");

    // R9: write wins over read, rdata holds
    acc(1'b1, 1'b1, 1'b0, 16'h03C6, 16'h0012, "R9 rd+wr");
    check(rdata, 8'h00, "R9 rdata held on rd+wr");
    rdv(16'h03C6, 8'h12, "R9 write took effect");
    acc(1'b0, 1'b0, 1'b0, 16'h03C6, 16'h0000, "R9 idle");
    check(rdata, 8'h12, "R9 rdata held idle");

    // Mixed traffic against the model
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] p;
      logic [1:0]  kind;
      p    = 16'($urandom_range(16'h03DB, 16'h03BF));
      kind = 2'($urandom_range(3, 0));
      acc(kind == 2'd0 || kind == 2'd3, kind != 2'd0, kind == 2'd2,
          p, 16'($urandom), "R2 R6 R8 mixed");
    end

    finish_run();
  end

endmodule